// File: doc/BRIEF.md
# Encoded-Operation 32-bit ALU

This block is a purely combinational arithmetic-logic unit for a simple integer datapath. It takes two 32-bit operands and a 4-bit operation code, and it returns a 32-bit result in the same cycle. The supported operations are bitwise AND, bitwise OR, addition, subtraction and signed set-less-than. The block has no clock, no reset and no stored state.

The operation code packs two controls into one field. Bit 2 makes the shared adder invert B and add a carry of one, so subtraction and set-less-than use the same adder as addition. The remaining bits select which internal result is driven out. The block has no shifter and no status flags. A code outside the five defined values drives a result of zero.

Top module: `alu_enc`

## Requirements
- R1: Code 4'b0000 drives `result_o` with the bitwise AND of `a_i` and `b_i`.
- R2: Code 4'b0001 drives `result_o` with the bitwise OR of `a_i` and `b_i`.
- R3: Code 4'b0010 drives `result_o` with `a_i + b_i` modulo 2^32. A carry out of bit 31 is dropped and no flag is raised.
- R4: Code 4'b0110 drives `result_o` with `a_i - b_i` modulo 2^32. A borrow wraps silently.
- R5: Code 4'b0111 drives `result_o` with 1 when `a_i` is less than `b_i` as signed two's-complement values, and with 0 otherwise. Bits 31..1 of the result are always zero, including when the difference overflows.
- R6: Each of the eleven other codes drives `result_o` with all zeros, whatever the operand values are.
- R7: `result_o` depends only on the present values of `a_i`, `b_i` and `op_i`. When the inputs change, the output settles within the same cycle, and the same inputs always give the same output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, or the subtrahend |
| op_i | input | 4 | Operation code; bit 2 enables subtraction |
| result_o | output | 32 | Combinational result |

## Verification
The checks assume that the three inputs are stable whenever they are evaluated. They also assume that `op_i` carries only known bit values, so that every code falls either into the five defined operations or into the undefined set.

The bench changes inputs only on rising edges of its pacing clock and reads `result_o` on the falling edge. By that point the combinational output has settled on the new inputs. The stimulus drives all sixteen codes with known operand values, so every path through the decoder is exercised without leaving that assumed input space.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned SUB_BIT = 2;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111
  } alu_op_e;

  typedef struct packed {
    logic and_sel;
    logic or_sel;
    logic sum_sel;
    logic slt_sel;
  } alu_sel_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output alu_sel_t        sel_o,
  output logic            sub_en_o
);
  // Adder inverts B whenever bit 2 is set; undefined codes select nothing.
  assign sub_en_o = op_i[SUB_BIT];

  always_comb begin
    sel_o = '0;
    unique case (op_i)
      OP_AND:  sel_o.and_sel = 1'b1;
      OP_OR:   sel_o.or_sel  = 1'b1;
      OP_ADD,
      OP_SUB:  sel_o.sum_sel = 1'b1;
      OP_SLT:  sel_o.slt_sel = 1'b1;
      default: sel_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_en_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             lt_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             ovf;

  assign b_eff = sub_en_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_en_i};

  // Signed overflow: like-signed inputs, result sign differs.
  assign ovf  = ~(a_i[MSB] ^ b_eff[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
  assign lt_o = sum_o[MSB] ^ ovf;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
  end
endmodule

// File: rtl/alu_enc.sv
module alu_enc
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o
);
  alu_sel_t         sel;
  logic             sub_en;
  logic [WIDTH-1:0] sum, and_r, or_r, slt_r;
  logic             lt;

  alu_decode i_decode (
    .op_i     (op_i),
    .sel_o    (sel),
    .sub_en_o (sub_en)
  );

  alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_en_i (sub_en),
    .sum_o    (sum),
    .lt_o     (lt)
  );

  alu_logic #(.WIDTH(WIDTH)) i_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_r),
    .or_o  (or_r)
  );

  assign slt_r = {{(WIDTH-1){1'b0}}, lt};

  // One-hot AND-OR mux; an empty select yields zero.
  assign result_o = ({WIDTH{sel.and_sel}} & and_r)
                  | ({WIDTH{sel.or_sel}}  & or_r)
                  | ({WIDTH{sel.sum_sel}} & sum)
                  | ({WIDTH{sel.slt_sel}} & slt_r);
endmodule

// File: rtl/alu_enc_chk.sv
module alu_enc_chk
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] result_o
);
  logic [WIDTH-1:0] diff;
  assign diff = a_i - b_i;

  always_comb begin
    if (op_i == OP_AND) p_and_r1: assert (result_o == (a_i & b_i));
    if (op_i == OP_OR)  p_or_r2:  assert (result_o == (a_i | b_i));
    if (op_i == OP_ADD) p_add_wrap_r3: assert (result_o == a_i + b_i);
    if (op_i == OP_SUB) p_sub_wrap_r4: assert (result_o == diff);
    if (op_i == OP_SLT) begin
      p_slt_value_r5: assert (result_o[0] == ($signed(a_i) < $signed(b_i)));
      p_slt_upper_r5: assert (result_o[WIDTH-1:1] == '0);
    end
    if (!(op_i inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT}))
      p_undef_zero_r6: assert (result_o == '0);
  end
endmodule

bind alu_enc alu_enc_chk #(.WIDTH(WIDTH)) i_alu_enc_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .result_o (result_o)
);

// File: tb/test_alu_enc.sv
module test_alu_enc;
  localparam int unsigned W          = 32;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned NVEC       = 16;
  localparam int unsigned WATCHDOG   = 10000;

  // {req, op, a, b, expected}
  localparam logic [103:0] VEC [NVEC] = '{
    {4'd1, 4'b0000, 32'hffff0000, 32'h0f0f0f0f, 32'h0f0f0000},
    {4'd1, 4'b0000, 32'haaaaaaaa, 32'h55555555, 32'h00000000},
    {4'd2, 4'b0001, 32'haaaaaaaa, 32'h55555555, 32'hffffffff},
    {4'd2, 4'b0001, 32'h12340000, 32'h00005678, 32'h12345678},
    {4'd3, 4'b0010, 32'h00000005, 32'h00000007, 32'h0000000c},
    {4'd3, 4'b0010, 32'hffffffff, 32'h00000001, 32'h00000000},
    {4'd3, 4'b0010, 32'h7fffffff, 32'h00000001, 32'h80000000},
    {4'd4, 4'b0110, 32'h0000000a, 32'h00000003, 32'h00000007},
    {4'd4, 4'b0110, 32'h00000000, 32'h00000001, 32'hffffffff},
    {4'd4, 4'b0110, 32'h80000000, 32'h00000001, 32'h7fffffff},
    {4'd5, 4'b0111, 32'hffffffff, 32'h00000001, 32'h00000001},
    {4'd5, 4'b0111, 32'h00000001, 32'hffffffff, 32'h00000000},
    {4'd5, 4'b0111, 32'h80000000, 32'h7fffffff, 32'h00000001},
    {4'd5, 4'b0111, 32'h7fffffff, 32'h80000000, 32'h00000000},
    {4'd5, 4'b0111, 32'h00000005, 32'h00000005, 32'h00000000},
    {4'd6, 4'b0011, 32'hffffffff, 32'h00000001, 32'h00000000}
  };

  logic           clk = 1'b0;
  logic [W-1:0]   a = '0, b = '0;
  logic [3:0]     op = 4'b0000;
  logic [W-1:0]   result;
  int unsigned    n_chk = 0, n_bad = 0;
  int unsigned    cycles = 0;
  bit             done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_enc i_alu_enc (
    .a_i      (a),
    .b_i      (b),
    .op_i     (op),
    .result_o (result)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, op, a, b, result, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] model(input logic [3:0] o, input logic [W-1:0] x,
                                         input logic [W-1:0] y);
    case (o)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return ($signed(x) < $signed(y)) ? 1 : 0;
      default: return '0;
    endcase
  endfunction

  initial begin
    // Idle state: all inputs zero, AND selected -> zero (R1)
    @(negedge clk);
    check("R1", '0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32]);
      check($sformatf("R%0d", VEC[i][103:100]), VEC[i][31:0]);
    end

    // R6: every undefined code gives zero with all-ones operands
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cc = c[3:0];
      if (!(cc inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111})) begin
        apply(cc, '1, '1);
        check("R6", '0);
      end
    end

    // R5: mixed-sign and minimum-value edge cases
    apply(4'b0111, 32'h80000000, 32'h00000000); check("R5", 32'h1);
    apply(4'b0111, 32'h00000000, 32'h80000000); check("R5", 32'h0);
    apply(4'b0111, 32'hfffffffe, 32'hffffffff); check("R5", 32'h1);

    // R7: repeat inputs after a different op; output tracks inputs only
    apply(4'b0010, 32'h00001000, 32'h00000234); check("R7", 32'h00001234);
    apply(4'b0110, 32'h00001000, 32'h00000234); check("R7", 32'h00000dcc);
    apply(4'b0010, 32'h00001000, 32'h00000234); check("R7", 32'h00001234);

    // Sweep every code against the reference model (R1..R6)
    for (int c = 0; c < 16; c++) begin
      apply(c[3:0], 32'h9abcdef0, 32'h12345678);
      check("R1_R6_sweep", model(c[3:0], 32'h9abcdef0, 32'h12345678));
    end

    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end else if (cycles > WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule